// File: doc/BRIEF.md
# Banked Reduction Accumulator

This block collects result vectors from a dot-product unit and keeps them in a small set of accumulator banks. Each bank holds a number of rows, and each row is a vector of signed 32-bit lanes. A command either overwrites a row with a bias vector or adds an incoming vector onto it. Results from many matrix-multiply steps can therefore be summed in place. Each bank is addressed on its own, so one bank can be filled while another is being read out.

Partial sums from an adjacent processing element arrive on a separate valid/ready receive port. Each one is added onto a chosen row of a chosen local bank. A drain command reads every row of one bank in order and sends it to one of three sinks. The sinks are the neighbour transmit port, the downstream forward port, or a local memory write port. While a bank is being drained it is marked busy, and nothing can modify it.

Top module: `banked_reduce_acc`

## Requirements
- R1: After reset every row of every bank reads as zero, `bank_busy` is all zero, and `nbr_tx_valid`, `fwd_valid` and `mem_we` are low.
- R2: A command with `cmd_op` = 1 (preset) replaces row `cmd_row` of bank `cmd_bank` with `cmd_data`.
- R3: A command with `cmd_op` = 2 (accumulate) adds `cmd_data` to row `cmd_row` of bank `cmd_bank`. Lane i occupies bits [32i+31:32i], and each lane sum wraps modulo 2^32, for example 0x7FFFFFFF + 1 = 0x80000000.
- R4: A write to one bank leaves every row of every other bank unchanged. This holds even while another bank is busy.
- R5: `nbr_rx_ready` is high exactly when bank `nbr_rx_bank` is not busy and no preset or accumulate command to that same bank is presented in that cycle. An accepted receive adds `nbr_rx_data` lane-wise, with wraparound, onto row `nbr_rx_row` of that bank.
- R6: A drain command selects its sink through `cmd_op`: 3 sends to the neighbour port, 4 to the forward port and 5 to memory. From the cycle after it is accepted, the block presents rows 0 to ROWS-1 of the bank in order on `out_data`, together with `out_bank` and `out_row`. Only the valid signal of the selected sink is high. The neighbour and forward ports move one row per cycle in which ready is high and hold the same row otherwise. The memory port writes one row per cycle at `mem_addr` = {bank, row}. Draining does not clear the bank.
- R7: `bank_busy[b]` is high from the cycle after a drain of bank b is accepted until the cycle after its last row is transferred. At most one drain runs at a time.
- R8: While bank b is busy, every preset, accumulate or receive aimed at b has no effect. Any drain command issued while a drain is running is ignored.
- R9: A receive and a drain command for the same bank in the same cycle are serialized with the receive first: the receive is accepted and the drained row includes it.
- R10: `cmd_op` values 0, 6 and 7 have no effect on any bank or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code (see R2, R3, R6, R10) |
| cmd_bank | input | 2 | Target bank |
| cmd_row | input | 2 | Target row for preset and accumulate |
| cmd_data | input | 128 | Bias or dot-product vector, 4 lanes of 32 bits |
| nbr_rx_valid | input | 1 | Partial sum from neighbour present |
| nbr_rx_ready | output | 1 | Partial sum accepted this cycle |
| nbr_rx_bank | input | 2 | Bank that receives the partial sum |
| nbr_rx_row | input | 2 | Row that receives the partial sum |
| nbr_rx_data | input | 128 | Partial sum vector |
| bank_busy | output | 4 | One bit per bank, high while draining |
| out_bank | output | 2 | Bank of the row being drained |
| out_row | output | 2 | Index of the row being drained |
| out_data | output | 128 | Contents of the row being drained |
| nbr_tx_valid | output | 1 | Drained row offered to the neighbour |
| nbr_tx_ready | input | 1 | Neighbour takes the row |
| fwd_valid | output | 1 | Drained row offered downstream |
| fwd_ready | input | 1 | Downstream takes the row |
| mem_we | output | 1 | Drained row written to local memory |
| mem_addr | output | 4 | Memory row address {bank, row} |

## Verification
The bench builds the block with its defaults: four banks of four rows, and four 32-bit lanes. With these sizes the full bank and row fields are used, the last row closes every drain, and lane wraparound can be produced by chosen values. It mixes directed cases with a long random run. The directed cases are wraparound, a receive colliding with a command, a receive paired with a drain, writes to a busy bank and a held-off sink. The random run covers presets, accumulates and receives, and its drains stall at random on ready.

// File: rtl/bra_pkg.sv
// Shared definitions for the banked reduction accumulator.
// Assumes a 3-bit command opcode; codes 6 and 7 are unused.
package bra_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_PRESET = 3'd1,
        OP_ACCUM  = 3'd2,
        OP_TO_NBR = 3'd3,
        OP_TO_FWD = 3'd4,
        OP_TO_MEM = 3'd5
    } bra_op_e;

    typedef enum logic [1:0] {
        DST_NBR = 2'd0,
        DST_FWD = 2'd1,
        DST_MEM = 2'd2
    } bra_dst_e;

endpackage

// File: rtl/bra_vec_add.sv
// Lane-wise adder: adds two vectors of LANES signed lanes.
// Each lane wraps modulo 2^LANE_W. The adder is purely combinational.
module bra_vec_add #(
    parameter int LANES  = 4,
    parameter int LANE_W = 32,
    localparam int VEC_W = LANES * LANE_W
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    output logic [VEC_W-1:0] sum_o
);

    // One independent wrapping adder per lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign sum_o[l*LANE_W +: LANE_W] = a_i[l*LANE_W +: LANE_W] + b_i[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/bra_bank.sv
// One accumulator bank of ROWS vector rows with a single write port.
// A write either replaces the row (add_i low) or adds onto it (add_i high).
// There is an asynchronous read port for draining. The caller must never
// raise we_i while busy_i is high. ROWS is assumed to be a power of two.
module bra_bank #(
    parameter int ROWS   = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 32,
    localparam int VEC_W = LANES * LANE_W,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic             we_i,
    input  logic             add_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [VEC_W-1:0] data_i,
    input  logic [ROW_W-1:0] rd_row_i,
    output logic [VEC_W-1:0] rd_data_o
);

    logic [ROWS-1:0][VEC_W-1:0] store_q;
    logic [VEC_W-1:0]           sum;

    bra_vec_add #(.LANES(LANES), .LANE_W(LANE_W)) i_add (
        .a_i   (store_q[row_i]),
        .b_i   (data_i),
        .sum_o (sum)
    );

    // Row storage: cleared on reset, then preset or accumulated on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (we_i) begin
            store_q[row_i] <= add_i ? sum : data_i;
        end
    end

    // Read port for the drain engine.
    assign rd_data_o = store_q[rd_row_i];

    // R8: a busy bank keeps its contents unchanged.
    a_r8_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(store_q));

endmodule

// File: rtl/bra_drain.sv
// Drain engine: walks rows 0..ROWS-1 of one bank towards one sink.
// The neighbour and forward sinks use valid/ready. The memory sink
// accepts a row every cycle. A start request is taken only while idle.
module bra_drain
    import bra_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROWS      = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ROW_W    = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BANK_W-1:0] bank_i,
    input  bra_dst_e          dst_i,
    input  logic              nbr_ready_i,
    input  logic              fwd_ready_i,
    output logic              active_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o,
    output logic              nbr_valid_o,
    output logic              fwd_valid_o,
    output logic              mem_we_o
);

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    logic              active_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    bra_dst_e          dst_q;
    logic              step;

    // Sink valids and the row-advance condition.
    always_comb begin
        nbr_valid_o = active_q && (dst_q == DST_NBR);
        fwd_valid_o = active_q && (dst_q == DST_FWD);
        mem_we_o    = active_q && (dst_q == DST_MEM);
        step        = mem_we_o || (nbr_valid_o && nbr_ready_i) || (fwd_valid_o && fwd_ready_i);
    end

    // Engine state: capture a start, then advance one row per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            bank_q   <= '0;
            row_q    <= '0;
            dst_q    <= DST_MEM;
        end else if (start_i && !active_q) begin
            active_q <= 1'b1;
            bank_q   <= bank_i;
            row_q    <= '0;
            dst_q    <= dst_i;
        end else if (step) begin
            row_q <= row_q + 1'b1;
            if (row_q == LAST_ROW) begin
                active_q <= 1'b0;
            end
        end
    end

    assign active_o = active_q;
    assign bank_o   = bank_q;
    assign row_o    = row_q;

    // R6: at most one sink is driven at a time.
    a_r6_one_sink: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nbr_valid_o, fwd_valid_o, mem_we_o}));

    // R6: a completed transfer that is not the last moves to the next row.
    a_r6_row_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step && row_q != LAST_ROW) |=> (active_o && row_o == $past(row_o) + 1'b1));

    // R6: a stalled handshake sink keeps the same row on offer.
    a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        ((nbr_valid_o && !nbr_ready_i) || (fwd_valid_o && !fwd_ready_i))
        |=> (active_o && $stable(row_o) && $stable(bank_o)));

    // R7: the engine goes idle right after the last row is transferred.
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (step && row_q == LAST_ROW) |=> !active_o);

endmodule

// File: rtl/banked_reduce_acc.sv
// Banked reduction accumulator top.
// Decodes commands, gates the neighbour receive port, steers one write per
// bank per cycle and hands drained rows to the selected sink. Preset and
// accumulate commands take priority over a receive into the same bank,
// which is held off through nbr_rx_ready. A busy bank takes no writes.
module banked_reduce_acc
    import bra_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROWS      = 4,
    parameter int LANES     = 4,
    parameter int LANE_W    = 32,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ROW_W    = $clog2(ROWS),
    localparam int VEC_W    = LANES * LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [2:0]              cmd_op,
    input  logic [BANK_W-1:0]       cmd_bank,
    input  logic [ROW_W-1:0]        cmd_row,
    input  logic [VEC_W-1:0]        cmd_data,
    input  logic                    nbr_rx_valid,
    output logic                    nbr_rx_ready,
    input  logic [BANK_W-1:0]       nbr_rx_bank,
    input  logic [ROW_W-1:0]        nbr_rx_row,
    input  logic [VEC_W-1:0]        nbr_rx_data,
    output logic [NUM_BANKS-1:0]    bank_busy,
    output logic [BANK_W-1:0]       out_bank,
    output logic [ROW_W-1:0]        out_row,
    output logic [VEC_W-1:0]        out_data,
    output logic                    nbr_tx_valid,
    input  logic                    nbr_tx_ready,
    output logic                    fwd_valid,
    input  logic                    fwd_ready,
    output logic                    mem_we,
    output logic [BANK_W+ROW_W-1:0] mem_addr
);

    logic              is_write;
    logic              is_drain;
    logic              cmd_wr;
    logic              rx_fire;
    logic              drain_start;
    bra_dst_e          start_dst;
    logic              drn_active;
    logic [BANK_W-1:0] drn_bank;
    logic [ROW_W-1:0]  drn_row;
    logic [VEC_W-1:0]  bank_rd [NUM_BANKS];

    // Command decode and admission against the busy bank.
    always_comb begin
        is_write    = cmd_valid && (cmd_op == OP_PRESET || cmd_op == OP_ACCUM);
        is_drain    = cmd_valid && (cmd_op == OP_TO_NBR || cmd_op == OP_TO_FWD || cmd_op == OP_TO_MEM);
        cmd_wr      = is_write && !(drn_active && drn_bank == cmd_bank);
        drain_start = is_drain && !drn_active;
        case (cmd_op)
            OP_TO_NBR: start_dst = DST_NBR;
            OP_TO_FWD: start_dst = DST_FWD;
            default:   start_dst = DST_MEM;
        endcase
    end

    // Receive admission: blocked by a busy bank or a command to the same bank.
    always_comb begin
        nbr_rx_ready = !(drn_active && drn_bank == nbr_rx_bank) &&
                       !(is_write && cmd_bank == nbr_rx_bank);
        rx_fire      = nbr_rx_valid && nbr_rx_ready;
    end

    // Per-bank busy flag derived from the single drain engine.
    always_comb begin
        bank_busy = '0;
        if (drn_active) begin
            bank_busy[drn_bank] = 1'b1;
        end
    end

    // Bank array with per-bank write steering.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             hit_cmd;
        logic             hit_rx;
        logic             we;
        logic             add;
        logic [ROW_W-1:0] row;
        logic [VEC_W-1:0] data;

        assign hit_cmd = cmd_wr && (cmd_bank == BANK_W'(b));
        assign hit_rx  = rx_fire && (nbr_rx_bank == BANK_W'(b));
        assign we      = hit_cmd || hit_rx;
        assign add     = hit_cmd ? (cmd_op == OP_ACCUM) : 1'b1;
        assign row     = hit_cmd ? cmd_row : nbr_rx_row;
        assign data    = hit_cmd ? cmd_data : nbr_rx_data;

        bra_bank #(.ROWS(ROWS), .LANES(LANES), .LANE_W(LANE_W)) i_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .busy_i    (bank_busy[b]),
            .we_i      (we),
            .add_i     (add),
            .row_i     (row),
            .data_i    (data),
            .rd_row_i  (drn_row),
            .rd_data_o (bank_rd[b])
        );
    end

    bra_drain #(.NUM_BANKS(NUM_BANKS), .ROWS(ROWS)) i_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (drain_start),
        .bank_i      (cmd_bank),
        .dst_i       (start_dst),
        .nbr_ready_i (nbr_tx_ready),
        .fwd_ready_i (fwd_ready),
        .active_o    (drn_active),
        .bank_o      (drn_bank),
        .row_o       (drn_row),
        .nbr_valid_o (nbr_tx_valid),
        .fwd_valid_o (fwd_valid),
        .mem_we_o    (mem_we)
    );

    // Output row bus shared by the three sinks.
    assign out_bank = drn_bank;
    assign out_row  = drn_row;
    assign out_data = bank_rd[drn_bank];
    assign mem_addr = {drn_bank, drn_row};

    // R7: a bank only becomes busy in response to a drain command.
    a_r7_busy_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|bank_busy) |-> $past(cmd_valid && cmd_op >= 3'd3 && cmd_op <= 3'd5));

    // R7: one drain at a time.
    a_r7_single_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_busy));

endmodule

// File: tb/test_banked_reduce_acc.sv
// Self-checking bench for banked_reduce_acc: directed cases plus seeded random traffic.
module test_banked_reduce_acc;

    localparam int NB = 4, ROWS = 4, LANES = 4, W = 32, VW = LANES * W;
    localparam logic [2:0] C_NOP = 3'd0, C_SET = 3'd1, C_ADD = 3'd2,
                           C_NBR = 3'd3, C_FWD = 3'd4, C_MEM = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [1:0] cmd_bank = '0;
    logic [1:0] cmd_row = '0;
    logic [VW-1:0] cmd_data = '0;
    logic nbr_rx_valid = 1'b0;
    logic nbr_rx_ready;
    logic [1:0] nbr_rx_bank = '0;
    logic [1:0] nbr_rx_row = '0;
    logic [VW-1:0] nbr_rx_data = '0;
    logic [NB-1:0] bank_busy;
    logic [1:0] out_bank;
    logic [1:0] out_row;
    logic [VW-1:0] out_data;
    logic nbr_tx_valid;
    logic nbr_tx_ready = 1'b1;
    logic fwd_valid;
    logic fwd_ready = 1'b1;
    logic mem_we;
    logic [3:0] mem_addr;

    int errors = 0;
    int checks = 0;
    logic [VW-1:0] model [NB][ROWS];

    always #10 clk = ~clk;

    banked_reduce_acc i_banked_reduce_acc (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_data(cmd_data),
        .nbr_rx_valid(nbr_rx_valid), .nbr_rx_ready(nbr_rx_ready),
        .nbr_rx_bank(nbr_rx_bank), .nbr_rx_row(nbr_rx_row), .nbr_rx_data(nbr_rx_data),
        .bank_busy(bank_busy), .out_bank(out_bank), .out_row(out_row), .out_data(out_data),
        .nbr_tx_valid(nbr_tx_valid), .nbr_tx_ready(nbr_tx_ready),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
        .mem_we(mem_we), .mem_addr(mem_addr)
    );

    function automatic logic [VW-1:0] vadd(logic [VW-1:0] a, logic [VW-1:0] b);
        logic [VW-1:0] r;
        for (int l = 0; l < LANES; l++) r[l*W +: W] = a[l*W +: W] + b[l*W +: W];
        return r;
    endfunction

    function automatic logic [VW-1:0] rvec();
        logic [VW-1:0] r;
        for (int l = 0; l < LANES; l++) r[l*W +: W] = $urandom;
        return r;
    endfunction

    task automatic chk(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Drive a command and optionally a receive for one cycle; update the model.
    task automatic step_both(bit cv, logic [2:0] op, int cb, int cr, logic [VW-1:0] cd,
                             bit rv, int rb, int rr, logic [VW-1:0] rd, bit exp_rdy, string tag);
        cmd_valid = cv; cmd_op = op; cmd_bank = 2'(cb); cmd_row = 2'(cr); cmd_data = cd;
        nbr_rx_valid = rv; nbr_rx_bank = 2'(rb); nbr_rx_row = 2'(rr); nbr_rx_data = rd;
        #1;
        if (rv) chk({tag, " rx_ready"}, VW'(nbr_rx_ready), VW'(exp_rdy));
        if (cv && op == C_SET) model[cb][cr] = cd;
        if (cv && op == C_ADD) model[cb][cr] = vadd(model[cb][cr], cd);
        if (rv && exp_rdy) model[rb][rr] = vadd(model[rb][rr], rd);
        @(negedge clk);
        cmd_valid = 1'b0; nbr_rx_valid = 1'b0;
    endtask

    // Follow a running drain of bank b, checking every row (R6, R7).
    task automatic drain_follow(logic [2:0] op, int b, bit stall, string tag);
        int r = 0;
        int guard = 0;
        bit rdy;
        logic [2:0] exp_v;
        exp_v = (op == C_NBR) ? 3'b100 : (op == C_FWD) ? 3'b010 : 3'b001;
        while (r < ROWS && guard < 200) begin
            rdy = stall ? 1'($urandom % 2) : 1'b1;
            nbr_tx_ready = rdy; fwd_ready = rdy;
            #1;
            chk({tag, " R6 ctl"}, VW'({nbr_tx_valid, fwd_valid, mem_we, bank_busy, out_bank, out_row}),
                VW'({exp_v, 4'(1 << b), 2'(b), 2'(r)}));
            chk({tag, " R6 data"}, out_data, model[b][r]);
            if (op == C_MEM) chk({tag, " R6 addr"}, VW'(mem_addr), VW'({2'(b), 2'(r)}));
            @(negedge clk);
            if (op == C_MEM || rdy) r++;
            guard++;
        end
        nbr_tx_ready = 1'b1; fwd_ready = 1'b1;
        #1;
        chk({tag, " R7 released"}, VW'({nbr_tx_valid, fwd_valid, mem_we, bank_busy}), '0);
    endtask

    task automatic drain(logic [2:0] op, int b, bit stall, string tag);
        step_both(1'b1, op, b, 0, '0, 1'b0, 0, 0, '0, 1'b0, tag);
        drain_follow(op, b, stall, tag);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [VW-1:0] v;
        int seed_dummy;
        seed_dummy = $urandom(32'd4321);
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < ROWS; r++) model[b][r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state of outputs and banks.
        chk("R1 reset outputs", VW'({bank_busy, nbr_tx_valid, fwd_valid, mem_we}), '0);
        @(negedge clk);
        for (int b = 0; b < NB; b++) drain(C_MEM, b, 1'b0, "R1 zero bank");

        // R2: preset replaces a row.
        v = {32'd44, 32'd33, 32'd22, 32'd11};
        step_both(1'b1, C_ADD, 1, 2, {4{32'd5}}, 1'b0, 0, 0, '0, 1'b0, "R2 pre");
        step_both(1'b1, C_SET, 1, 2, v, 1'b0, 0, 0, '0, 1'b0, "R2 set");
        chk("R2 model literal", model[1][2], v);
        drain(C_FWD, 1, 1'b0, "R2 preset");

        // R3: lane wraparound with literal expectation.
        step_both(1'b1, C_SET, 0, 0, {32'h00000001, 32'h80000000, 32'hFFFFFFFF, 32'h7FFFFFFF},
                  1'b0, 0, 0, '0, 1'b0, "R3 set");
        step_both(1'b1, C_ADD, 0, 0, {32'd5, 32'hFFFFFFFF, 32'd1, 32'd1},
                  1'b0, 0, 0, '0, 1'b0, "R3 add");
        chk("R3 wrap literal", model[0][0], {32'd6, 32'h7FFFFFFF, 32'h0, 32'h80000000});
        drain(C_MEM, 0, 1'b0, "R3 wrap");

        // R5: receive accepted; receive blocked by command to the same bank; other bank accepted.
        step_both(1'b0, C_NOP, 0, 0, '0, 1'b1, 3, 1, {4{32'd7}}, 1'b1, "R5 rx alone");
        step_both(1'b1, C_ADD, 3, 0, {4{32'd2}}, 1'b1, 3, 1, {4{32'd100}}, 1'b0, "R5 rx collide");
        step_both(1'b1, C_SET, 3, 2, {4{32'd9}}, 1'b1, 2, 3, {4{32'd8}}, 1'b1, "R5 rx other bank");
        drain(C_NBR, 3, 1'b1, "R5 bank3");
        drain(C_NBR, 2, 1'b1, "R5 bank2");

        // R9: receive and drain to the same bank in one cycle.
        step_both(1'b1, C_FWD, 3, 0, '0, 1'b1, 3, 3, {4{32'h10}}, 1'b1, "R9 rx+drain");
        drain_follow(C_FWD, 3, 1'b1, "R9 drain");

        // R8 and R4: writes during a stalled drain of bank 2.
        fwd_ready = 1'b0;
        step_both(1'b1, C_FWD, 2, 0, '0, 1'b0, 0, 0, '0, 1'b0, "R8 start");
        fwd_ready = 1'b0;
        cmd_valid = 1'b1; cmd_op = C_ADD; cmd_bank = 2'd2; cmd_row = 2'd0; cmd_data = {4{32'd1}};
        nbr_rx_valid = 1'b1; nbr_rx_bank = 2'd2; nbr_rx_row = 2'd1; nbr_rx_data = {4{32'd3}};
        #1;
        chk("R8 rx blocked while busy", VW'(nbr_rx_ready), '0);
        @(negedge clk);
        cmd_op = C_SET; cmd_row = 2'd3; nbr_rx_valid = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        step_both(1'b1, C_SET, 1, 0, {4{32'hABCD}}, 1'b0, 0, 0, '0, 1'b0, "R4 other bank");
        fwd_ready = 1'b0;
        step_both(1'b1, C_MEM, 0, 0, '0, 1'b0, 0, 0, '0, 1'b0, "R8 second drain");
        fwd_ready = 1'b0;
        #1;
        chk("R8 second drain ignored", VW'({bank_busy, mem_we, fwd_valid, out_row}),
            VW'({4'b0100, 1'b0, 1'b1, 2'd0}));
        drain_follow(C_FWD, 2, 1'b1, "R8 unchanged");
        #1;
        chk("R8 no queued drain", VW'({mem_we, bank_busy}), '0);
        drain(C_MEM, 2, 1'b0, "R8 recheck");
        drain(C_FWD, 1, 1'b0, "R4 bank1");

        // R10: unused opcodes do nothing.
        step_both(1'b1, C_NOP, 1, 0, {4{32'h55}}, 1'b0, 0, 0, '0, 1'b0, "R10 op0");
        step_both(1'b1, 3'd6, 1, 0, {4{32'h66}}, 1'b0, 0, 0, '0, 1'b0, "R10 op6");
        step_both(1'b1, 3'd7, 1, 1, {4{32'h77}}, 1'b0, 0, 0, '0, 1'b0, "R10 op7");
        #1;
        chk("R10 no outputs", VW'({bank_busy, nbr_tx_valid, fwd_valid, mem_we}), '0);
        drain(C_MEM, 1, 1'b0, "R10 bank1");

        // Random traffic (R2, R3, R4, R5), then random drains (R6).
        for (int i = 0; i < 300; i++) begin
            int kind = $urandom % 4;
            int b = $urandom % NB;
            int r = $urandom % ROWS;
            int rb = $urandom % NB;
            int rr = $urandom % ROWS;
            case (kind)
                0: step_both(1'b1, C_SET, b, r, rvec(), 1'b0, 0, 0, '0, 1'b0, "R2 rand");
                1: step_both(1'b1, C_ADD, b, r, rvec(), 1'b0, 0, 0, '0, 1'b0, "R3 rand");
                2: step_both(1'b0, C_NOP, 0, 0, '0, 1'b1, rb, rr, rvec(), 1'b1, "R5 rand");
                default: step_both(1'b1, C_ADD, b, r, rvec(), 1'b1, rb, rr, rvec(), rb != b, "R5 rand mix");
            endcase
        end
        for (int b = 0; b < NB; b++) drain(3'(C_NBR + ($urandom % 3)), b, 1'b1, "R6 rand");

        report();
        $finish;
    end

endmodule